// File: doc/BRIEF.md
# Vector Lane Broadcast and Insert Unit

This block rearranges the lanes of a 64-bit vector value. A small lane immediate picks one 16-bit halfword or one 32-bit word of the source. That lane is then either copied into every lane of the result, or written into one lane of an old destination value while the other lanes keep their contents. The same unit extracts a single word into a general-register slot. It also splits a 64-bit vector into a pair of 32-bit general registers and joins such a pair back into a vector. It computes a saturating per-lane absolute value on halfword or word lanes.

One operation is issued per cycle with `op_valid`. The result is registered and appears on the cycle after issue, with `res_valid` marking it. No internal state sequence exists beyond this single result stage, which is either holding or loading. The register files that supply the sources and take the results sit outside the block.

Operation codes on `op_code`: 0 halfword broadcast, 1 word broadcast, 2 halfword insert, 3 word insert from vector, 4 word insert from general register, 5 word extract, 6 split to register pair, 7 join from register pair, 8 halfword absolute value, 9 word absolute value, and 10 to 15 undefined.

Top module: `lane_bcast_unit`

## Requirements
- R1: After reset, `res_valid`, `illegal`, `vec_res`, `gpr_lo_out` and `gpr_hi_out` are all zero.
- R2: An operation issued with `op_valid` high appears on the outputs at the next rising edge, with `res_valid` high for that one cycle. While `op_valid` is low, `res_valid` is low and the data outputs keep their last values.
- R3: Code 0 takes halfword `lane_idx` (0 selects bits 15:0 and 3 selects bits 63:48) of `vec_src` and repeats it in all four halfword lanes of `vec_res`.
- R4: Code 1 takes the low word of `vec_src` when `lane_idx` is 0, or bits 63:32 when it is 1, and repeats it in both word lanes of `vec_res`.
- R5: Code 2 writes `vec_src[15:0]` into halfword `lane_idx` of `vec_old` and outputs the result on `vec_res`, so the other three halfwords equal `vec_old`.
- R6: Code 3 writes `vec_src[31:0]`, and code 4 writes `gpr_lo_in`, into word `lane_idx` of `vec_old` (0 low, 1 high). The other word of `vec_old` is passed through unchanged.
- R7: Code 5 places the low word of `vec_src` (`lane_idx` 0) or bits 63:32 (`lane_idx` 1) on `gpr_lo_out`.
- R8: Code 6 puts `vec_src[31:0]` on `gpr_lo_out`, the even register, and `vec_src[63:32]` on `gpr_hi_out`, the odd register.
- R9: Code 7 drives `vec_res` with `{gpr_hi_in, gpr_lo_in}`.
- R10: Code 8 replaces each of the four signed halfword lanes of `vec_src` by its magnitude, and 16'h8000 becomes 16'h7FFF.
- R11: Code 9 replaces each of the two signed word lanes of `vec_src` by its magnitude, and 32'h80000000 becomes 32'h7FFFFFFF.
- R12: A word operation (codes 1, 3, 4, 5) with `lane_idx` 2 or 3, or any code from 10 to 15, sets `illegal` and forces all three data outputs to zero. A legal operation clears `illegal` and drives zero on every data output it does not define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 4 | Operation select (see list above) |
| lane_idx | input | 2 | Lane immediate |
| vec_src | input | 64 | Vector source value |
| vec_old | input | 64 | Current destination vector for inserts |
| gpr_lo_in | input | 32 | Even general register of the pair |
| gpr_hi_in | input | 32 | Odd general register of the pair |
| res_valid | output | 1 | Result registered from last cycle's issue |
| vec_res | output | 64 | Vector result |
| gpr_lo_out | output | 32 | Even register result |
| gpr_hi_out | output | 32 | Odd register result |
| illegal | output | 1 | Issued operation was undefined or out of range |

## Verification
The assertions assume that `op_code`, `lane_idx` and the data inputs are known and steady around the edge on which `op_valid` is sampled. Each check compares the output one edge later with the inputs that were sampled on that edge. The bench changes every input only on the falling clock edge and holds it for a full cycle. It lowers `op_valid` between operations, so each sampled operand belongs to exactly one issued operation.

// File: rtl/lane_pkg.sv
package lane_pkg;
    localparam int LB_VEC_W  = 64;
    localparam int LB_GPR_W  = 32;
    localparam int LB_HALF_W = 16;
    localparam int LB_CODE_W = 4;
    localparam int LB_IDX_W  = 2;

    typedef enum logic [LB_CODE_W-1:0] {
        OP_BCAST_H  = 4'd0,
        OP_BCAST_W  = 4'd1,
        OP_INS_H    = 4'd2,
        OP_INS_W_V  = 4'd3,
        OP_INS_W_G  = 4'd4,
        OP_EXT_W    = 4'd5,
        OP_SPLIT    = 4'd6,
        OP_JOIN     = 4'd7,
        OP_ABS_H    = 4'd8,
        OP_ABS_W    = 4'd9
    } lane_op_e;

    typedef struct packed {
        logic [LB_VEC_W-1:0] vec;
        logic [LB_GPR_W-1:0] lo;
        logic [LB_GPR_W-1:0] hi;
        logic                bad;
    } lane_res_t;
endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
    parameter int VEC_W  = 64,
    parameter int LANE_W = 16,
    localparam int NL    = VEC_W / LANE_W,
    localparam int SEL_W = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [VEC_W-1:0]  vec,
    input  logic [SEL_W-1:0]  sel,
    output logic [LANE_W-1:0] lane
);
    logic [LANE_W-1:0] lanes [NL];

    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign lanes[i] = vec[i*LANE_W +: LANE_W];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
    parameter int VEC_W  = 64,
    parameter int LANE_W = 16,
    localparam int NL    = VEC_W / LANE_W,
    localparam int SEL_W = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic [VEC_W-1:0]  old_vec,
    input  logic [LANE_W-1:0] val,
    input  logic [SEL_W-1:0]  sel,
    output logic [VEC_W-1:0]  merged
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] =
            (sel == SEL_W'(i)) ? val : old_vec[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/lane_abs.sv
module lane_abs #(
    parameter int VEC_W  = 64,
    parameter int LANE_W = 16,
    localparam int NL    = VEC_W / LANE_W
) (
    input  logic [VEC_W-1:0] vec,
    output logic [VEC_W-1:0] mag
);
    localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] MOST_POS = {1'b0, {(LANE_W-1){1'b1}}};

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LANE_W-1:0] x;
        assign x = vec[i*LANE_W +: LANE_W];
        assign mag[i*LANE_W +: LANE_W] =
            (x == MOST_NEG) ? MOST_POS :
            (x[LANE_W-1]    ? (~x + 1'b1) : x);
    end
endmodule

// File: rtl/lane_bcast_unit.sv
module lane_bcast_unit
    import lane_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [LB_CODE_W-1:0] op_code,
    input  logic [LB_IDX_W-1:0]  lane_idx,
    input  logic [LB_VEC_W-1:0]  vec_src,
    input  logic [LB_VEC_W-1:0]  vec_old,
    input  logic [LB_GPR_W-1:0]  gpr_lo_in,
    input  logic [LB_GPR_W-1:0]  gpr_hi_in,
    output logic                 res_valid,
    output logic [LB_VEC_W-1:0]  vec_res,
    output logic [LB_GPR_W-1:0]  gpr_lo_out,
    output logic [LB_GPR_W-1:0]  gpr_hi_out,
    output logic                 illegal
);
    localparam int HL = LB_VEC_W / LB_HALF_W;
    localparam int WL = LB_VEC_W / LB_GPR_W;

    lane_op_e   op;
    lane_res_t  res_q, res_d;
    logic       valid_q;

    logic [LB_HALF_W-1:0] pick_h;
    logic [LB_GPR_W-1:0]  pick_w;
    logic [LB_GPR_W-1:0]  ins_w_val;
    logic [LB_VEC_W-1:0]  ins_h, ins_w, abs_h, abs_w;
    logic                 word_bad;

    assign op       = lane_op_e'(op_code);
    assign word_bad = lane_idx[1];
    assign ins_w_val = (op == OP_INS_W_G) ? gpr_lo_in : vec_src[LB_GPR_W-1:0];

    lane_pick #(.VEC_W(LB_VEC_W), .LANE_W(LB_HALF_W)) u_pick_h (
        .vec(vec_src), .sel(lane_idx), .lane(pick_h));

    lane_pick #(.VEC_W(LB_VEC_W), .LANE_W(LB_GPR_W)) u_pick_w (
        .vec(vec_src), .sel(lane_idx[0]), .lane(pick_w));

    lane_merge #(.VEC_W(LB_VEC_W), .LANE_W(LB_HALF_W)) u_ins_h (
        .old_vec(vec_old), .val(vec_src[LB_HALF_W-1:0]), .sel(lane_idx),
        .merged(ins_h));

    lane_merge #(.VEC_W(LB_VEC_W), .LANE_W(LB_GPR_W)) u_ins_w (
        .old_vec(vec_old), .val(ins_w_val), .sel(lane_idx[0]),
        .merged(ins_w));

    lane_abs #(.VEC_W(LB_VEC_W), .LANE_W(LB_HALF_W)) u_abs_h (
        .vec(vec_src), .mag(abs_h));

    lane_abs #(.VEC_W(LB_VEC_W), .LANE_W(LB_GPR_W)) u_abs_w (
        .vec(vec_src), .mag(abs_w));

    // next result selection
    always_comb begin
        res_d = '0;
        case (op)
            OP_BCAST_H: res_d.vec = {HL{pick_h}};
            OP_BCAST_W: begin
                if (word_bad) res_d.bad = 1'b1;
                else          res_d.vec = {WL{pick_w}};
            end
            OP_INS_H:   res_d.vec = ins_h;
            OP_INS_W_V,
            OP_INS_W_G: begin
                if (word_bad) res_d.bad = 1'b1;
                else          res_d.vec = ins_w;
            end
            OP_EXT_W: begin
                if (word_bad) res_d.bad = 1'b1;
                else          res_d.lo  = pick_w;
            end
            OP_SPLIT: begin
                res_d.lo = vec_src[LB_GPR_W-1:0];
                res_d.hi = vec_src[LB_VEC_W-1:LB_GPR_W];
            end
            OP_JOIN:    res_d.vec = {gpr_hi_in, gpr_lo_in};
            OP_ABS_H:   res_d.vec = abs_h;
            OP_ABS_W:   res_d.vec = abs_w;
            default:    res_d.bad = 1'b1;
        endcase
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= op_valid;
            if (op_valid) res_q <= res_d;
        end
    end

    assign res_valid  = valid_q;
    assign vec_res    = res_q.vec;
    assign gpr_lo_out = res_q.lo;
    assign gpr_hi_out = res_q.hi;
    assign illegal    = res_q.bad;
endmodule

// File: rtl/lane_bcast_unit_chk.sv
module lane_bcast_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op_code,
    input logic [1:0]  lane_idx,
    input logic [63:0] vec_src,
    input logic [63:0] vec_old,
    input logic [31:0] gpr_lo_in,
    input logic [31:0] gpr_hi_in,
    input logic        res_valid,
    input logic [63:0] vec_res,
    input logic [31:0] gpr_lo_out,
    input logic [31:0] gpr_hi_out,
    input logic        illegal
);
    logic [63:0] keep_h;
    logic        word_op;

    assign keep_h  = ~(64'hFFFF << {lane_idx, 4'b0000});
    assign word_op = (op_code == 4'd1) || (op_code == 4'd3) ||
                     (op_code == 4'd4) || (op_code == 4'd5);

    // R2
    issue_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R2
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_valid);

    // R3
    half_bcast_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=>
            (vec_res[15:0] == vec_res[31:16]) && (vec_res[31:16] == vec_res[47:32]) &&
            (vec_res[47:32] == vec_res[63:48]));

    // R4
    word_bcast_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd1 && !lane_idx[1]) |=>
            (vec_res[31:0] == vec_res[63:32]) && !illegal);

    // R5
    half_insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |=>
            (((vec_res ^ $past(vec_old)) & $past(keep_h)) == 64'd0));

    // R9
    join_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd7) |=>
            (vec_res == {$past(gpr_hi_in), $past(gpr_lo_in)}));

    // R10
    half_abs_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=>
            !vec_res[15] && !vec_res[31] && !vec_res[47] && !vec_res[63]);

    // R12
    word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && word_op && lane_idx[1]) |=> illegal);

    // R12
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && illegal) |->
            (vec_res == 64'd0) && (gpr_lo_out == 32'd0) && (gpr_hi_out == 32'd0));
endmodule

bind lane_bcast_unit lane_bcast_unit_chk u_chk (.*);

// File: tb/lane_bcast_unit_tb.sv
`timescale 1ns/1ps
module lane_bcast_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  lane_idx = '0;
    logic [63:0] vec_src = '0;
    logic [63:0] vec_old = '0;
    logic [31:0] gpr_lo_in = '0;
    logic [31:0] gpr_hi_in = '0;
    logic        res_valid;
    logic [63:0] vec_res;
    logic [31:0] gpr_lo_out;
    logic [31:0] gpr_hi_out;
    logic        illegal;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    lane_bcast_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .lane_idx(lane_idx), .vec_src(vec_src), .vec_old(vec_old),
        .gpr_lo_in(gpr_lo_in), .gpr_hi_in(gpr_hi_in), .res_valid(res_valid),
        .vec_res(vec_res), .gpr_lo_out(gpr_lo_out), .gpr_hi_out(gpr_hi_out),
        .illegal(illegal));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one operation, return after the result is registered
    task automatic issue(input logic [3:0] code, input logic [1:0] idx,
                         input logic [63:0] src, input logic [63:0] old,
                         input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; lane_idx = idx;
        vec_src = src; vec_old = old; gpr_lo_in = lo; gpr_hi_in = hi;
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2 valid", {63'd0, res_valid}, 64'd1);
    endtask

    task automatic expect_out(input string req, input logic [63:0] v,
                              input logic [31:0] lo, input logic [31:0] hi,
                              input logic bad);
        chk(req, vec_res, v);
        chk(req, {32'd0, gpr_lo_out}, {32'd0, lo});
        chk(req, {32'd0, gpr_hi_out}, {32'd0, hi});
        chk(req, {63'd0, illegal}, {63'd0, bad});
    endtask

    task automatic t_reset;
        expect_out("R1 reset", 64'd0, 32'd0, 32'd0, 1'b0);
        chk("R1 reset valid", {63'd0, res_valid}, 64'd0);
    endtask

    task automatic t_bcast_h;
        logic [63:0] src = 64'h4444_3333_2222_1111;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] h = src[k*16 +: 16];
            issue(4'd0, 2'(k), src, 64'hFFFF_FFFF_FFFF_FFFF, 32'h5, 32'h6);
            expect_out("R3 half broadcast", {4{h}}, 32'd0, 32'd0, 1'b0);
        end
    endtask

    task automatic t_bcast_w;
        issue(4'd1, 2'd0, 64'hDEADBEEF_01234567, '0, '0, '0);
        expect_out("R4 word broadcast low", 64'h01234567_01234567, 0, 0, 1'b0);
        issue(4'd1, 2'd1, 64'hDEADBEEF_01234567, '0, '0, '0);
        expect_out("R4 word broadcast high", 64'hDEADBEEF_DEADBEEF, 0, 0, 1'b0);
        issue(4'd1, 2'd2, 64'hDEADBEEF_01234567, '0, '0, '0);
        expect_out("R12 word broadcast index 2", 64'd0, 0, 0, 1'b1);
    endtask

    task automatic t_ins_h;
        logic [63:0] old = 64'hAAAA_BBBB_CCCC_DDDD;
        for (int k = 0; k < 4; k++) begin
            logic [63:0] e = old;
            e[k*16 +: 16] = 16'h1234;
            issue(4'd2, 2'(k), 64'h9999_8888_7777_1234, old, '0, '0);
            expect_out("R5 half insert", e, 0, 0, 1'b0);
        end
    endtask

    task automatic t_ins_w;
        issue(4'd3, 2'd1, 64'h5555_5555_CAFE_F00D, 64'h11111111_22222222, 32'h0BADC0DE, '0);
        expect_out("R6 word insert vector high", 64'hCAFEF00D_22222222, 0, 0, 1'b0);
        issue(4'd4, 2'd0, 64'h5555_5555_CAFE_F00D, 64'h11111111_22222222, 32'h0BADC0DE, '0);
        expect_out("R6 word insert gpr low", 64'h11111111_0BADC0DE, 0, 0, 1'b0);
        issue(4'd4, 2'd3, 64'h5555_5555_CAFE_F00D, 64'h11111111_22222222, 32'h0BADC0DE, '0);
        expect_out("R12 word insert index 3", 64'd0, 0, 0, 1'b1);
    endtask

    task automatic t_ext;
        issue(4'd5, 2'd0, 64'h89ABCDEF_76543210, '1, '0, '0);
        expect_out("R7 extract low", 64'd0, 32'h76543210, 0, 1'b0);
        issue(4'd5, 2'd1, 64'h89ABCDEF_76543210, '1, '0, '0);
        expect_out("R7 extract high", 64'd0, 32'h89ABCDEF, 0, 1'b0);
    endtask

    task automatic t_pair;
        issue(4'd6, 2'd0, 64'hFEDCBA98_13579BDF, '0, '0, '0);
        expect_out("R8 split", 64'd0, 32'h13579BDF, 32'hFEDCBA98, 1'b0);
        issue(4'd7, 2'd3, '1, '0, 32'hA5A5_0F0F, 32'h3C3C_9696);
        expect_out("R9 join", 64'h3C3C9696_A5A50F0F, 0, 0, 1'b0);
    endtask

    task automatic t_abs;
        issue(4'd8, 2'd0, 64'h8000_FFFD_7FFF_0005, '0, '0, '0);
        expect_out("R10 half abs", 64'h7FFF_0003_7FFF_0005, 0, 0, 1'b0);
        issue(4'd9, 2'd0, 64'h80000000_FFFFFFFE, '0, '0, '0);
        expect_out("R11 word abs", 64'h7FFFFFFF_00000002, 0, 0, 1'b0);
        issue(4'd9, 2'd0, 64'h00001234_FFFFFFFF, '0, '0, '0);
        expect_out("R11 word abs small", 64'h00001234_00000001, 0, 0, 1'b0);
    endtask

    task automatic t_bad_code;
        issue(4'd12, 2'd0, 64'h1234_5678_9ABC_DEF0, '1, '1, '1);
        expect_out("R12 undefined code", 64'd0, 0, 0, 1'b1);
    endtask

    task automatic t_hold;
        issue(4'd7, 2'd0, '0, '0, 32'h0000_0042, 32'h0000_0024);
        @(negedge clk);
        op_code = 4'd0; vec_src = '1; gpr_lo_in = '0; gpr_hi_in = '0;
        @(negedge clk);
        chk("R2 idle valid low", {63'd0, res_valid}, 64'd0);
        chk("R2 hold result", vec_res, 64'h00000024_00000042);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bcast_h();
        t_bcast_w();
        t_ins_h();
        t_ins_w();
        t_ext();
        t_pair();
        t_abs();
        t_bad_code();
        t_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule